// File: doc/BRIEF.md
# Half-Word Parallel Interface Adapter

This block sits between a protocol device and a serializer core. On the transmit side it collects 10-bit code groups from the device. On the receive side it returns the code groups that the serializer core recovered. A mode input picks one of two pin formats. In full-word mode a whole 10-bit group crosses the pins once per word period. In half-word mode only five pins are used: each word crosses in two halves, the lower half in the first phase of the word clock and the upper half in the second. The receive side also drives two byte clock outputs, so that the device can latch the received data.

Nothing in the block uses both clock edges. It runs on a single fast clock that is four times the word rate, and a free-running 2-bit phase counter marks where each half of the word period begins and ends. The word clock that the device sees (`ref_clk`) is decoded from that counter. Both byte clocks come from the counter, from the parity of the received word and from the selected clock style. A change of pin format throws away any half-built word, and the next word starts again with a lower half.

Top module: `pif_word_adapter`

## Requirements
- R1: The phase counter is 0 while `rst` is high and then advances by one on every `clk` edge. `ref_clk` is high while the counter reads 0 or 1 and low while it reads 2 or 3, so the word period is four `clk` cycles.
- R2: Full-word mode (`half_mode`=0). `tx_pin_data` is sampled on the edge at which the counter moves from 1 to 2. For the following cycle only, `tx_word` shows that value and `tx_word_vld` is high. Values on the pins at any other edge are ignored.
- R3: Half-word mode (`half_mode`=1). `tx_pin_data[4:0]` is taken on the 1-to-2 edge and becomes `tx_word[4:0]`. `tx_pin_data[4:0]` on the following 3-to-0 edge becomes `tx_word[9:5]`. `tx_word_vld` pulses for the cycle after that second edge. Bit 0 is the first bit for serialization, and `tx_pin_data[9:5]` is ignored.
- R4: Full-word mode. `rx_word` is sampled on the 1-to-2 edge and is driven on `rx_pin_data` for the next four cycles.
- R5: Half-word mode. After the 1-to-2 edge, `rx_pin_data[4:0]` carries bits 0–4 of the sampled word. After the 3-to-0 edge it carries bits 5–9. `rx_pin_data[9:5]` is driven 0.
- R6: Full-word mode with `bclk_word_rate`=0. `byte_clk_b` is high for the second half of every even-numbered received word and the first half of every odd one. `byte_clk_a` is its complement. Both have a period of eight cycles. Words are numbered from 0 after reset, and `byte_clk_b` rises at counter value 0 of an even word.
- R7: Full-word mode with `bclk_word_rate`=1. `byte_clk_a` is high while the counter reads 0 or 1, and `byte_clk_b` stays 0.
- R8: Half-word mode. `byte_clk_a` is high while the counter reads 3 or 0, and `byte_clk_b` stays 0, whatever the level of `bclk_word_rate`. Receive data therefore changes at both levels of `byte_clk_a`.
- R9: On an edge where `half_mode` differs from the mode currently held, the block adopts the new mode and captures nothing. Any stored lower half is dropped, so no word is emitted until a new lower half and upper half have both arrived.
- R10: While `rst` is high, `tx_word`, `tx_word_vld` and `rx_pin_data` are 0, and both byte clocks are held low. Both byte clocks stay low after reset until the first received word is on `rx_pin_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per word period |
| rst | input | 1 | Synchronous reset, active high |
| half_mode | input | 1 | 0: full 10-bit pins, 1: 5-bit halves |
| bclk_word_rate | input | 1 | Full-word mode only. 1: one byte clock at the word rate, 0: two half-rate byte clocks |
| tx_pin_data | input | 10 | Transmit pins from the protocol device |
| tx_word | output | 10 | Assembled code group for the serializer, bit 0 sent first |
| tx_word_vld | output | 1 | One-cycle pulse marking a new `tx_word` |
| rx_word | input | 10 | Code group recovered by the deserializer |
| rx_pin_data | output | 10 | Receive pins to the protocol device |
| ref_clk | output | 1 | Word clock decoded from the phase counter |
| byte_clk_a | output | 1 | First byte clock |
| byte_clk_b | output | 1 | Second byte clock |

## Verification
The hardest case to reach from the ports is a format change that arrives after a lower half has been stored but before its upper half. The stimulus aims at this window. It flips `half_mode` to full and then back just after a lower-half edge, so that the change lands on the upper-half edge. It then confirms that no pulse appears on `tx_word_vld` and that `tx_word` keeps its old value until a fresh pair of halves has arrived. The byte clock phases in half-rate style rely on word parity counted from reset. For that reason each style is run from reset over 32 words, so every parity and every phase is seen.

// File: rtl/pif_adapter_pkg.sv
package pif_adapter_pkg;

  typedef enum logic {
    IFM_FULL = 1'b0,
    IFM_HALF = 1'b1
  } ifm_e;

  typedef enum logic [1:0] {
    BCS_HALF_RATE = 2'd0,
    BCS_WORD      = 2'd1,
    BCS_DDR       = 2'd2
  } bcs_e;

  // Phase counter values whose closing edge carries a capture.
  localparam logic [1:0] PH_LO_LAST = 2'd1;
  localparam logic [1:0] PH_HI_LAST = 2'd3;

  function automatic bcs_e pick_style(ifm_e mode, logic word_rate);
    if (mode == IFM_HALF) return BCS_DDR;
    if (word_rate)        return BCS_WORD;
    return BCS_HALF_RATE;
  endfunction

  // Returns {clk_b, clk_a}.
  function automatic logic [1:0] clk_levels(bcs_e style, logic [1:0] cnt,
                                            logic odd_word, logic started);
    logic a;
    logic b;
    a = 1'b0;
    b = 1'b0;
    unique case (style)
      BCS_DDR:  a = (cnt == 2'd3) || (cnt == 2'd0);
      BCS_WORD: a = !cnt[1];
      default: begin
        b = odd_word ? cnt[1] : !cnt[1];
        a = !b;
      end
    endcase
    return started ? {b, a} : 2'b00;
  endfunction

endpackage

// File: rtl/pif_phase_gen.sv
module pif_phase_gen
  import pif_adapter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       half_mode_i,
  output logic [1:0] cnt_o,
  output logic       lo_stb_o,
  output logic       hi_stb_o,
  output logic       ref_clk_o,
  output ifm_e       mode_q_o,
  output logic       mode_chg_o
);

  logic [1:0] cnt_q;
  ifm_e       mode_q;
  ifm_e       mode_in;

  assign mode_in = ifm_e'(half_mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= 2'd0;
      mode_q <= mode_in;
    end else begin
      cnt_q <= cnt_q + 2'd1;
      if (mode_in != mode_q) mode_q <= mode_in;
    end
  end

  assign cnt_o      = cnt_q;
  assign lo_stb_o   = (cnt_q == PH_LO_LAST);
  assign hi_stb_o   = (cnt_q == PH_HI_LAST);
  assign ref_clk_o  = !cnt_q[1];
  assign mode_q_o   = mode_q;
  assign mode_chg_o = (mode_in != mode_q);

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) + 2'd1);

endmodule

// File: rtl/pif_tx_pack.sv
module pif_tx_pack
  import pif_adapter_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ifm_e              mode_q,
  input  logic              mode_chg,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [1:0]        cnt,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] word_q;
  logic [HALF_W-1:0] lo_q;
  logic              have_lo;
  logic              vld_q;

  function automatic logic [WORD_W-1:0] join_halves(logic [HALF_W-1:0] hi,
                                                    logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      lo_q    <= '0;
      have_lo <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (mode_chg) begin
        have_lo <= 1'b0;
      end else if (mode_q == IFM_FULL) begin
        have_lo <= 1'b0;
        if (lo_stb) begin
          word_q <= din;
          vld_q  <= 1'b1;
        end
      end else begin
        if (lo_stb) begin
          lo_q    <= din[HALF_W-1:0];
          have_lo <= 1'b1;
        end else if (hi_stb && have_lo) begin
          word_q  <= join_halves(din[HALF_W-1:0], lo_q);
          vld_q   <= 1'b1;
          have_lo <= 1'b0;
        end
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  assert_full_vld_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == IFM_FULL) |-> $past(cnt) == PH_LO_LAST);

  assert_half_vld_phase_R3: assert property (@(posedge clk) disable iff (rst)
    (vld_q && mode_q == IFM_HALF) |-> $past(cnt) == PH_HI_LAST);

  assert_chg_no_word_R9: assert property (@(posedge clk) disable iff (rst)
    $past(mode_chg) |-> !vld_q);

endmodule

// File: rtl/pif_rx_unpack.sv
module pif_rx_unpack
  import pif_adapter_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ifm_e              mode_q,
  input  logic              mode_chg,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] data_o,
  output logic              odd_word_o,
  output logic              started_o
);

  localparam int HALF_W = WORD_W / 2;
  localparam int PAD_W  = WORD_W - HALF_W;

  logic [WORD_W-1:0] data_q;
  logic [HALF_W-1:0] hi_q;
  logic              hi_ok;
  logic              started;
  logic [1:0]        idx_q;

  function automatic logic [WORD_W-1:0] pad_half(logic [HALF_W-1:0] h);
    return {{PAD_W{1'b0}}, h};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      hi_q    <= '0;
      hi_ok   <= 1'b0;
      started <= 1'b0;
      idx_q   <= 2'd0;
    end else if (mode_chg) begin
      hi_ok <= 1'b0;
    end else if (lo_stb) begin
      started <= 1'b1;
      idx_q   <= started ? idx_q + 2'd1 : 2'd0;
      hi_q    <= din[WORD_W-1:HALF_W];
      hi_ok   <= 1'b1;
      data_q  <= (mode_q == IFM_HALF) ? pad_half(din[HALF_W-1:0]) : din;
    end else if (hi_stb && mode_q == IFM_HALF) begin
      data_q <= hi_ok ? pad_half(hi_q) : '0;
      hi_ok  <= 1'b0;
    end
  end

  assign data_o     = data_q;
  assign odd_word_o = idx_q[0];
  assign started_o  = started;

  assert_full_word_out_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == IFM_FULL && $past(mode_q) == IFM_FULL && $past(lo_stb))
      |-> data_q == $past(din));

  assert_half_upper_low_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == IFM_HALF && $past(mode_q) == IFM_HALF && $past(lo_stb || hi_stb))
      |-> data_q[WORD_W-1:HALF_W] == '0);

endmodule

// File: rtl/pif_byte_clk.sv
module pif_byte_clk
  import pif_adapter_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cnt,
  input  ifm_e       mode_q,
  input  logic       word_rate,
  input  logic       odd_word,
  input  logic       started,
  output logic       clk_a_o,
  output logic       clk_b_o
);

  bcs_e       style;
  logic [1:0] lv;

  assign style   = pick_style(mode_q, word_rate);
  assign lv      = clk_levels(style, cnt, odd_word, started);
  assign clk_a_o = lv[0];
  assign clk_b_o = lv[1];

  assert_half_rate_even_R6: assert property (@(posedge clk) disable iff (rst)
    (style == BCS_HALF_RATE && $past(style) == BCS_HALF_RATE && $rose(clk_b_o))
      |-> (!odd_word && cnt == 2'd0));

  assert_word_rate_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (style == BCS_WORD && $past(style) == BCS_WORD && $rose(clk_a_o))
      |-> cnt == 2'd0);

  assert_ddr_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (style == BCS_DDR && $past(style) == BCS_DDR && $rose(clk_a_o))
      |-> cnt == 2'd3);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !started |-> (!clk_a_o && !clk_b_o));

endmodule

// File: rtl/pif_word_adapter.sv
module pif_word_adapter
  import pif_adapter_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  input  logic              bclk_word_rate,
  input  logic [WORD_W-1:0] tx_pin_data,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_word_vld,
  input  logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] rx_pin_data,
  output logic              ref_clk,
  output logic              byte_clk_a,
  output logic              byte_clk_b
);

  logic [1:0] cnt;
  logic       lo_stb;
  logic       hi_stb;
  ifm_e       mode_q;
  logic       mode_chg;
  logic       odd_word;
  logic       started;

  pif_phase_gen u_phase (
    .clk         (clk),
    .rst         (rst),
    .half_mode_i (half_mode),
    .cnt_o       (cnt),
    .lo_stb_o    (lo_stb),
    .hi_stb_o    (hi_stb),
    .ref_clk_o   (ref_clk),
    .mode_q_o    (mode_q),
    .mode_chg_o  (mode_chg)
  );

  pif_tx_pack #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .mode_chg (mode_chg),
    .lo_stb   (lo_stb),
    .hi_stb   (hi_stb),
    .cnt      (cnt),
    .din      (tx_pin_data),
    .word_o   (tx_word),
    .vld_o    (tx_word_vld)
  );

  pif_rx_unpack #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .mode_chg   (mode_chg),
    .lo_stb     (lo_stb),
    .hi_stb     (hi_stb),
    .din        (rx_word),
    .data_o     (rx_pin_data),
    .odd_word_o (odd_word),
    .started_o  (started)
  );

  pif_byte_clk u_bclk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .mode_q    (mode_q),
    .word_rate (bclk_word_rate),
    .odd_word  (odd_word),
    .started   (started),
    .clk_a_o   (byte_clk_a),
    .clk_b_o   (byte_clk_b)
  );

endmodule

// File: tb/tb_pif_word_adapter.sv
module tb_pif_word_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_mode = 1'b0;
  logic       bclk_word_rate = 1'b0;
  logic [9:0] tx_pin_data = '0;
  logic [9:0] rx_word = '0;
  logic [9:0] tx_word;
  logic       tx_word_vld;
  logic [9:0] rx_pin_data;
  logic       ref_clk;
  logic       byte_clk_a;
  logic       byte_clk_b;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pif_word_adapter dut (
    .clk            (clk),
    .rst            (rst),
    .half_mode      (half_mode),
    .bclk_word_rate (bclk_word_rate),
    .tx_pin_data    (tx_pin_data),
    .tx_word        (tx_word),
    .tx_word_vld    (tx_word_vld),
    .rx_word        (rx_word),
    .rx_pin_data    (rx_pin_data),
    .ref_clk        (ref_clk),
    .byte_clk_a     (byte_clk_a),
    .byte_clk_b     (byte_clk_b)
  );

  function automatic logic [9:0] pat(int w, int cfg);
    return 10'((w * 41 + cfg * 97 + 13) % 1024);
  endfunction

  task automatic chk(bit ok, string tag, logic [9:0] act, logic [9:0] exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive pins for edge e = k+1 (half or full format, junk elsewhere).
  task automatic drive(int k, bit m, int cfg);
    int e;
    logic [9:0] junk;
    logic [9:0] p;
    e = k + 1;
    junk = ~pat(e, cfg + 3);
    if (!m) begin
      tx_pin_data = (e % 4 == 2) ? pat((e - 2) / 4, cfg) : junk;
    end else if (e % 4 == 2) begin
      p = pat((e - 2) / 4, cfg);
      tx_pin_data = {junk[9:5], p[4:0]};
    end else if (e % 4 == 0 && e >= 4) begin
      p = pat((e - 4) / 4, cfg);
      tx_pin_data = {junk[9:5], p[9:5]};
    end else begin
      tx_pin_data = junk;
    end
    rx_word = pat((k + 1) / 4, cfg + 5);
  endtask

  task automatic do_reset(bit m, bit b);
    @(negedge clk);
    rst = 1'b1;
    half_mode = m;
    bclk_word_rate = b;
    repeat (3) @(negedge clk);
    chk(tx_word == 0 && !tx_word_vld, "R10 tx in reset", tx_word, 10'h0);
    chk(rx_pin_data == 0, "R10 rx in reset", rx_pin_data, 10'h0);
    chk(!byte_clk_a && !byte_clk_b, "R10 byte clocks in reset",
        {8'h0, byte_clk_b, byte_clk_a}, 10'h0);
  endtask

  task automatic sample(int k, bit m, bit b, int cfg);
    int c;
    int w;
    bit st;
    bit ea;
    bit eb;
    bit ev;
    logic [9:0] p;
    logic [9:0] er;
    c = k % 4;
    chk(ref_clk == (c < 2), "R1 ref_clk", {9'h0, ref_clk}, {9'h0, c < 2});
    if (!m) begin
      ev = (c == 2) && k >= 2;
      chk(tx_word_vld == ev, "R2 tx_word_vld", {9'h0, tx_word_vld}, {9'h0, ev});
      if (ev) chk(tx_word == pat((k - 2) / 4, cfg), "R2 tx_word", tx_word,
                  pat((k - 2) / 4, cfg));
    end else begin
      ev = (c == 0) && k >= 4;
      chk(tx_word_vld == ev, "R3 tx_word_vld", {9'h0, tx_word_vld}, {9'h0, ev});
      if (ev) chk(tx_word == pat((k - 4) / 4, cfg), "R3 tx_word", tx_word,
                  pat((k - 4) / 4, cfg));
    end
    st = (k >= 2);
    if (st) begin
      w = (k - 2) / 4;
      p = pat(w, cfg + 5);
      if (!m) begin
        chk(rx_pin_data == p, "R4 rx_pin_data", rx_pin_data, p);
      end else begin
        er = (c >= 2) ? {5'h0, p[4:0]} : {5'h0, p[9:5]};
        chk(rx_pin_data == er, "R5 rx_pin_data", rx_pin_data, er);
      end
    end else begin
      w = 0;
      chk(rx_pin_data == 0, "R10 rx before first word", rx_pin_data, 10'h0);
    end
    if (m) begin
      ea = st && (c == 3 || c == 0);
      eb = 1'b0;
      chk(byte_clk_a == ea && byte_clk_b == eb, "R8 byte clocks",
          {8'h0, byte_clk_b, byte_clk_a}, {8'h0, eb, ea});
    end else if (b) begin
      ea = st && (c < 2);
      eb = 1'b0;
      chk(byte_clk_a == ea && byte_clk_b == eb, "R7 byte clocks",
          {8'h0, byte_clk_b, byte_clk_a}, {8'h0, eb, ea});
    end else begin
      eb = st && (((w % 2 == 0) && c < 2) || ((w % 2 == 1) && c >= 2));
      ea = st && !eb;
      chk(byte_clk_a == ea && byte_clk_b == eb, "R6 byte clocks",
          {8'h0, byte_clk_b, byte_clk_a}, {8'h0, eb, ea});
    end
  endtask

  task automatic run_cfg(bit m, bit b, int cfg);
    do_reset(m, b);
    rst = 1'b0;
    drive(0, m, cfg);
    for (int k = 1; k <= NWORDS * 4 + 4; k++) begin
      @(negedge clk);
      sample(k, m, b, cfg);
      drive(k, m, cfg);
    end
  endtask

  // R9: format flips away and back right after a stored lower half.
  task automatic run_mode_flip(int cfg);
    do_reset(1'b1, 1'b0);
    rst = 1'b0;
    drive(0, 1'b1, cfg);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 4) chk(tx_word_vld && tx_word == pat(0, cfg), "R9 word before flip",
                      tx_word, pat(0, cfg));
      if (k >= 5 && k <= 11) chk(!tx_word_vld, "R9 no pulse after flip",
                                 {9'h0, tx_word_vld}, 10'h0);
      if (k == 11) chk(tx_word == pat(0, cfg), "R9 partial word dropped",
                       tx_word, pat(0, cfg));
      if (k == 12) chk(tx_word_vld && tx_word == pat(2, cfg), "R9 word after flip",
                       tx_word, pat(2, cfg));
      drive(k, 1'b1, cfg);
      if (k == 6) half_mode = 1'b0;
      if (k == 7) half_mode = 1'b1;
    end
  endtask

  initial begin
    run_cfg(1'b0, 1'b0, 1);
    run_cfg(1'b0, 1'b1, 2);
    run_cfg(1'b1, 1'b0, 3);
    run_cfg(1'b1, 1'b1, 4);
    run_mode_flip(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule